// File: doc/BRIEF.md
# Receive Message Queue with Foreground Slot

This block holds received controller-area-network frames that have already passed identifier matching and checksum checking. Each arriving frame (an 11-bit identifier, a 4-bit length code and eight data bytes) goes into a small first-in first-out store. The oldest stored frame is then copied into a single foreground slot. Software reads that slot directly from the output ports.

A "message ready" flag marks the foreground slot as occupied. While the flag is set, the slot is frozen and nothing moves up from the queue. Software reads the slot and then writes a one to the clear strobe. The next queued frame moves in one cycle later, and the flag sets again.

If a frame arrives when every queue entry is taken and no entry is leaving on that edge, the frame is thrown away and a separate overrun flag is raised. Two interrupt outputs follow the ready flag and the overrun flag. Each is gated by its own enable input.

Top module: `rx_msg_queue`

## Requirements
- R1: After a synchronous reset, both flags are 0, both interrupts are 0, the queue is empty and the foreground slot reads all zero. With no new frame, the ready flag stays 0.
- R2: Frames accepted on `in_valid` reach the foreground slot in arrival order. The identifier, length code and data bytes are kept unchanged.
- R3: When the ready flag is 0 and the queue holds a frame, the oldest frame is loaded into the slot on the next edge and the ready flag becomes 1. Starting from empty, a frame strobed at edge k shows in the slot, with the ready flag at 1, after edge k+1.
- R4: While the ready flag is 1, the foreground slot does not change and no entry leaves the queue.
- R5: `clr_ready` high on an edge where the ready flag is 1 clears the flag on that edge. If the queue is non-empty, the next frame is loaded on the following edge. `clr_ready` while the flag is 0 has no effect on the flag or the slot.
- R6: The queue holds DEPTH (default 4) frames behind the foreground slot. A frame arriving while the queue holds DEPTH frames and the ready flag is 1 is discarded, and the stored frames stay as they were.
- R7: A discarded frame sets the overrun flag. `clr_ovr` high clears it. If a discard and `clr_ovr` fall on the same edge, the flag ends up set.
- R8: When the queue is full and the ready flag is 0, a frame arriving on that edge is accepted, because the oldest entry leaves on the same edge.
- R9: `rx_irq` equals ready flag AND `rx_ie`. `err_irq` equals overrun flag AND `err_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: a correctly received frame is on the inputs |
| in_id | input | 11 | Frame identifier |
| in_len | input | 4 | Frame length code |
| in_data | input | 64 | Frame data bytes, byte 0 in bits 7:0 |
| clr_ready | input | 1 | Write-1 clear of the ready flag |
| clr_ovr | input | 1 | Write-1 clear of the overrun flag |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| fg_id | output | 11 | Foreground slot identifier |
| fg_len | output | 4 | Foreground slot length code |
| fg_data | output | 64 | Foreground slot data bytes |
| ready_flag | output | 1 | Foreground slot holds an unread frame |
| ovr_flag | output | 1 | A frame was discarded for lack of space |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions watch several rules on every cycle:
- the slot stays frozen while the ready flag is set;
- the flag sets whenever the slot is free and the queue holds a frame;
- a clear always drops the flag;
- a discard always leaves the overrun flag set;
- the occupancy count moves as pushes and pops dictate;
- the interrupts are masked.

Only the bench scenarios can show the following:
- frames come out in arrival order with their payload intact;
- a discarded frame truly vanishes while the stored ones survive;
- a push and a pop on the same edge when the queue is full accepts the arriving frame;
- the discard-wins-over-clear ordering.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ID_W   = 11;
  localparam int LEN_W  = 4;
  localparam int NBYTES = 8;
  localparam int DATA_W = NBYTES * 8;
  localparam int MSG_W  = ID_W + LEN_W + DATA_W;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int W     = 79
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_msg,
  input  logic         rd_en,
  output logic [W-1:0] rd_msg,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_msg;
  end

  assign rd_msg = mem[rd_ptr];
  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: a lone push raises occupancy by one
  a_r2_push_count: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (cnt == $past(cnt) + CW'(1)));
  // R6: a full queue with nothing leaving stays full
  a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);
endmodule

// File: rtl/rxq_fg.sv
module rxq_fg #(
  parameter int W = 79
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         q_empty,
  input  logic [W-1:0] q_head,
  input  logic         clr,
  output logic         pop,
  output logic [W-1:0] fg_msg,
  output logic         ready
);
  assign pop = !ready && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_msg <= '0;
      ready  <= 1'b0;
    end else if (pop) begin
      fg_msg <= q_head;
      ready  <= 1'b1;
    end else if (clr) begin
      ready  <= 1'b0;
    end
  end

  // R4: an occupied slot is frozen
  a_r4_slot_frozen: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(fg_msg));
  // R3: free slot plus waiting frame loads on the next edge
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (!ready && !q_empty) |=> ready);
  // R5: write-1 clear drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (ready && clr) |=> !ready);
endmodule

// File: rtl/rxq_evt.sv
module rxq_evt (
  input  logic clk,
  input  logic rst,
  input  logic drop,
  input  logic clr_ovr,
  input  logic ready,
  input  logic rx_ie,
  input  logic err_ie,
  output logic ovr,
  output logic rx_irq,
  output logic err_irq
);
  always_ff @(posedge clk) begin
    if (rst)          ovr <= 1'b0;
    else if (drop)    ovr <= 1'b1;
    else if (clr_ovr) ovr <= 1'b0;
  end

  assign rx_irq  = ready & rx_ie;
  assign err_irq = ovr & err_ie;

  // R7: a discard always leaves the overrun flag set
  a_r7_drop_sets: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr);
  // R9: masked interrupts stay low
  a_r9_rx_mask: assert property (@(posedge clk) disable iff (rst)
    !rx_ie |-> !rx_irq);
  a_r9_err_mask: assert property (@(posedge clk) disable iff (rst)
    !err_ie |-> !err_irq);
endmodule

// File: rtl/rx_msg_queue.sv
module rx_msg_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  input  logic              clr_ready,
  input  logic              clr_ovr,
  input  logic              rx_ie,
  input  logic              err_ie,
  output logic [ID_W-1:0]   fg_id,
  output logic [LEN_W-1:0]  fg_len,
  output logic [DATA_W-1:0] fg_data,
  output logic              ready_flag,
  output logic              ovr_flag,
  output logic              rx_irq,
  output logic              err_irq
);
  msg_t in_msg, head, fg;
  logic q_empty, q_full, pop, push, drop;

  assign in_msg = '{id: in_id, len: in_len, data: in_data};
  assign push   = in_valid && (!q_full || pop);
  assign drop   = in_valid && q_full && !pop;

  rxq_store #(.DEPTH(DEPTH), .W(MSG_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(push), .wr_msg(in_msg),
    .rd_en(pop), .rd_msg(head), .empty(q_empty), .full(q_full)
  );

  rxq_fg #(.W(MSG_W)) u_fg (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_head(head),
    .clr(clr_ready), .pop(pop), .fg_msg(fg), .ready(ready_flag)
  );

  rxq_evt u_evt (
    .clk(clk), .rst(rst), .drop(drop), .clr_ovr(clr_ovr),
    .ready(ready_flag), .rx_ie(rx_ie), .err_ie(err_ie),
    .ovr(ovr_flag), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  assign fg_id   = fg.id;
  assign fg_len  = fg.len;
  assign fg_data = fg.data;
endmodule

// File: tb/tb_rx_msg_queue.sv
module tb_rx_msg_queue;
  logic        clk = 0;
  logic        rst;
  logic        in_valid;
  logic [10:0] in_id;
  logic [3:0]  in_len;
  logic [63:0] in_data;
  logic        clr_ready, clr_ovr, rx_ie, err_ie;
  logic [10:0] fg_id;
  logic [3:0]  fg_len;
  logic [63:0] fg_data;
  logic        ready_flag, ovr_flag, rx_irq, err_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_msg_queue dut (.*);

  typedef struct packed {
    logic        vld;
    logic [10:0] id;
    logic        cr;
    logic        co;
    logic        er;
    logic [10:0] eid;
    logic        eo;
  } vec_t;

  function automatic vec_t v(int vld, int id, int cr, int co, int er, int eid, int eo);
    vec_t t;
    t.vld = vld[0]; t.id = id[10:0]; t.cr = cr[0]; t.co = co[0];
    t.er = er[0]; t.eid = eid[10:0]; t.eo = eo[0];
    return t;
  endfunction

  function automatic logic [3:0]  len_of(logic [10:0] id); return id[3:0]; endfunction
  function automatic logic [63:0] data_of(logic [10:0] id); return {8{id[7:0] ^ 8'h5A}}; endfunction

  localparam int N = 26;
  // vld id  clr_rdy clr_ovr | exp_ready exp_fg_id exp_ovr
  localparam vec_t TBL [N] = '{
    v(1,1, 0,0, 0,0,0),  // R3 first edge: stored only
    v(0,0, 0,0, 1,1,0),  // R3 loaded
    v(1,2, 0,0, 1,1,0),  // R4
    v(1,3, 0,0, 1,1,0),
    v(1,4, 0,0, 1,1,0),
    v(1,5, 0,0, 1,1,0),  // queue now full
    v(1,6, 0,0, 1,1,1),  // R6 drop, R7 set
    v(0,0, 0,0, 1,1,1),
    v(0,0, 1,0, 0,1,1),  // R5 clear
    v(0,0, 0,0, 1,2,1),  // R5 next one cycle later
    v(0,0, 0,1, 1,2,0),  // R7 clear
    v(1,7, 1,0, 0,2,0),
    v(1,8, 0,0, 1,3,0),  // R8 push+pop on full queue
    v(1,9, 0,0, 1,3,1),  // R6 drop
    v(1,10,1,1, 0,3,1),  // R7 drop beats clear
    v(0,0, 0,0, 1,4,1),  // R6 stored frames survived
    v(0,0, 0,1, 1,4,0),
    v(0,0, 1,0, 0,4,0),
    v(0,0, 0,0, 1,5,0),  // R2 order
    v(0,0, 1,0, 0,5,0),
    v(0,0, 0,0, 1,7,0),
    v(0,0, 1,0, 0,7,0),
    v(0,0, 0,0, 1,8,0),  // R8 accepted frame present
    v(0,0, 1,0, 0,8,0),
    v(0,0, 0,0, 0,8,0),  // empty, stays clear
    v(0,0, 1,0, 0,8,0)   // R5 clear while 0: no effect
  };

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic vld, logic [10:0] id, logic cr, logic co);
    @(negedge clk);
    in_valid = vld; in_id = id; in_len = len_of(id); in_data = data_of(id);
    clr_ready = cr; clr_ovr = co;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    rst = 1; in_valid = 0; in_id = 0; in_len = 0; in_data = 0;
    clr_ready = 0; clr_ovr = 0; rx_ie = 1; err_ie = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "ready", ready_flag, 0);
    check("R1", "ovr", ovr_flag, 0);
    check("R1", "fg_id", fg_id, 0);
    check("R1", "fg_data", fg_data, 0);
    check("R1", "irqs", {rx_irq, err_irq}, 0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < N; i++) begin
      step(TBL[i].vld, TBL[i].id, TBL[i].cr, TBL[i].co);
      check("R3/R4/R5", $sformatf("row%0d ready", i), ready_flag, TBL[i].er);
      check("R2/R4", $sformatf("row%0d fg_id", i), fg_id, TBL[i].eid);
      check("R6/R7", $sformatf("row%0d ovr", i), ovr_flag, TBL[i].eo);
      check("R9", $sformatf("row%0d irqs", i), {rx_irq, err_irq}, {TBL[i].er, TBL[i].eo});
      if (TBL[i].er) begin
        check("R2", $sformatf("row%0d len", i), fg_len, len_of(TBL[i].eid));
        check("R2", $sformatf("row%0d data", i), fg_data, data_of(TBL[i].eid));
      end
    end

    // R9 masking
    step(1, 11'd20, 0, 0);
    step(0, 0, 0, 0);
    check("R3", "ready after load", ready_flag, 1);
    rx_ie = 0; #1;
    check("R9", "rx_irq masked", rx_irq, 0);
    rx_ie = 1; #1;
    check("R9", "rx_irq enabled", rx_irq, 1);
    for (int k = 0; k < 5; k++) step(1, 11'(30 + k), 0, 0);
    check("R7", "ovr after overflow", ovr_flag, 1);
    err_ie = 0; #1;
    check("R9", "err_irq masked", err_irq, 0);
    err_ie = 1; #1;
    check("R9", "err_irq enabled", err_irq, 1);

    // R1 reset mid-run empties everything
    @(negedge clk); rst = 1; in_valid = 0;
    @(posedge clk); #1;
    check("R1", "ready after reset", ready_flag, 0);
    check("R1", "ovr after reset", ovr_flag, 0);
    check("R1", "fg after reset", fg_id, 0);
    @(negedge clk); rst = 0;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check("R1", "queue empty after reset", ready_flag, 0);

    // R3 latency from empty
    step(1, 11'd33, 0, 0);
    check("R3", "not yet ready", ready_flag, 0);
    step(0, 0, 0, 0);
    check("R3", "ready", ready_flag, 1);
    check("R3", "fg_id", fg_id, 11'd33);

    done = 1;
    summary();
  end
endmodule